// File: doc/BRIEF.md
# Bus-Addressed I/O Port Responder

This block is the port-access slice of a device sitting on a shared 8-bit data bus that is steered by a 5-bit control code. The device holds a set of 8-bit output ports, a set of 8-bit input ports fed from external pins, and two write-only registers (a timer preset and an interrupt-control byte). Each of these sits at a port number set by a parameter.

A port access takes two back-to-back bus cycles. In the first cycle the data bus carries the port number. The second cycle carries either the write code (`5'h1A`) or the read code (`5'h1B`). The responder records the bus byte at the end of every cycle, so the port number is on hand when the access code arrives. On a write it loads the bus byte into the addressed register at the end of the cycle. On a read it drives the addressed readable port onto the bus during that same cycle, with its output enable raised.

The output-port, input-port and timer/interrupt numbers are parameters: output ports at `OUT_BASE`..`OUT_BASE+NUM_OUT-1`, input ports at `IN_BASE`..`IN_BASE+NUM_IN-1`, the timer at `TIMER_PORT` and interrupt control at `INTCTL_PORT`.

Top module: `io_port_responder`

## Requirements
- R1: At every rising clock edge the block stores the data-bus byte as the port address for the next cycle, whatever the control code. Back-to-back accesses therefore take their address from the bus byte of the cycle just before.
- R2: In a cycle with control code `5'h1A` and a stored address of `OUT_BASE+i`, output port i (bits `8*i+7:8*i` of `outPorts`) takes the current bus byte at the clock edge that ends the cycle.
- R3: In a `5'h1A` cycle with a stored address of `TIMER_PORT` or `INTCTL_PORT`, the timer or interrupt-control register takes the bus byte at the clock edge that ends the cycle.
- R4: In a `5'h1B` cycle with a stored address of `OUT_BASE+i`, `busOe` is 1 and `busOut` equals the last value written to output port i, within the same cycle.
- R5: In a `5'h1B` cycle with a stored address of `IN_BASE+j`, `busOe` is 1 and `busOut` equals `inPins[8*j+7:8*j]`.
- R6: In a `5'h1B` cycle whose stored address is `TIMER_PORT` or `INTCTL_PORT`, `busOe` stays 0, because the timer and interrupt-control registers cannot be read back.
- R7: If the stored address matches none of the block's port numbers, a `5'h1A` cycle changes no register and a `5'h1B` cycle keeps `busOe` at 0.
- R8: Any control code other than `5'h1A` leaves every register unchanged. Any control code other than `5'h1B` keeps `busOe` at 0.
- R9: While `rstN` is low, all output ports, the timer register, the interrupt-control register and the stored address are 0x00, and `busOe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus cycle clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctlCode | input | 5 | Control code for the current bus cycle |
| busIn | input | 8 | Data bus value seen by the device |
| inPins | input | 8*NUM_IN | External input port pins, port j in byte j |
| busOut | output | 8 | Byte driven onto the bus on a read hit (0 otherwise) |
| busOe | output | 1 | Bus drive enable |
| outPorts | output | 8*NUM_OUT | Output port registers, port i in byte i |
| timerReg | output | 8 | Timer preset register |
| intCtlReg | output | 8 | Interrupt-control register |

## Verification
The assertions check four things on every cycle: the bus drive never rises outside a read cycle, never exposes the write-only registers, and never answers an unmatched address; non-write cycles leave every register still; and a read hit returns the matching output-port or input-pin byte. What these cycle-local rules cannot show is the two-cycle pairing itself. That the address comes from the exact bus byte of the previous cycle, including chains where a write's data byte becomes the next access's address, is shown only by the bench's directed and pseudo-random sequences, compared each cycle against its own model.

// File: rtl/io_resp_pkg.sv
package io_resp_pkg;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_OUT,
    TGT_IN,
    TGT_TIMER,
    TGT_INTCTL
  } tgt_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       wrEn;
    logic       rdEn;
    tgt_e       tgt;
    logic [7:0] idx;
  } strobe_t;

endpackage

// File: rtl/io_resp_ctrl.sv
module io_resp_ctrl
  import io_resp_pkg::*;
#(
  parameter int unsigned NUM_OUT     = 2,
  parameter int unsigned NUM_IN      = 2,
  parameter int unsigned OUT_BASE    = 4,
  parameter int unsigned IN_BASE     = 8,
  parameter int unsigned TIMER_PORT  = 12,
  parameter int unsigned INTCTL_PORT = 13,
  parameter logic [4:0]  WR_CODE     = 5'h1A,
  parameter logic [4:0]  RD_CODE     = 5'h1B
) (
  input  logic [4:0] ctlCode,
  input  logic [7:0] prevAddr,
  output strobe_t    stb
);

  tgt_e       tgt;
  logic [7:0] idx;

  // decode the address captured in the previous cycle
  always_comb begin
    int unsigned a;
    a   = int'(prevAddr);
    tgt = TGT_NONE;
    idx = 8'h00;
    if (a >= OUT_BASE && a < OUT_BASE + NUM_OUT) begin
      tgt = TGT_OUT;
      idx = 8'(a - OUT_BASE);
    end else if (a >= IN_BASE && a < IN_BASE + NUM_IN) begin
      tgt = TGT_IN;
      idx = 8'(a - IN_BASE);
    end else if (a == TIMER_PORT) begin
      tgt = TGT_TIMER;
    end else if (a == INTCTL_PORT) begin
      tgt = TGT_INTCTL;
    end
  end

  always_comb begin
    stb.tgt  = tgt;
    stb.idx  = idx;
    // input pins have no register to load
    stb.wrEn = (ctlCode == WR_CODE) && (tgt != TGT_NONE) && (tgt != TGT_IN);
    // write-only registers never answer a read
    stb.rdEn = (ctlCode == RD_CODE) && ((tgt == TGT_OUT) || (tgt == TGT_IN));
  end

endmodule

// File: rtl/io_resp_dp.sv
module io_resp_dp
  import io_resp_pkg::*;
#(
  parameter int unsigned NUM_OUT = 2,
  parameter int unsigned NUM_IN  = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [7:0]           busIn,
  input  logic [8*NUM_IN-1:0]  inPins,
  input  strobe_t              stb,
  output logic [7:0]           prevAddr,
  output logic [8*NUM_OUT-1:0] outPorts,
  output logic [7:0]           timerReg,
  output logic [7:0]           intCtlReg,
  output logic [7:0]           busOut,
  output logic                 busOe
);

  logic [7:0] outReg [NUM_OUT];

  // bus byte of every cycle becomes the next cycle's port address
  always_ff @(posedge clk) begin
    if (!rstN) prevAddr <= 8'h00;
    else       prevAddr <= busIn;
  end

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    always_ff @(posedge clk) begin
      if (!rstN)
        outReg[i] <= 8'h00;
      else if (stb.wrEn && stb.tgt == TGT_OUT && stb.idx == 8'(i))
        outReg[i] <= busIn;
    end
    assign outPorts[8*i +: 8] = outReg[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timerReg  <= 8'h00;
      intCtlReg <= 8'h00;
    end else if (stb.wrEn) begin
      if (stb.tgt == TGT_TIMER)  timerReg  <= busIn;
      if (stb.tgt == TGT_INTCTL) intCtlReg <= busIn;
    end
  end

  // read mux
  always_comb begin
    busOut = 8'h00;
    if (stb.rdEn) begin
      for (int i = 0; i < NUM_OUT; i++)
        if (stb.tgt == TGT_OUT && stb.idx == 8'(i)) busOut = outReg[i];
      for (int j = 0; j < NUM_IN; j++)
        if (stb.tgt == TGT_IN && stb.idx == 8'(j)) busOut = inPins[8*j +: 8];
    end
  end

  assign busOe = stb.rdEn;

endmodule

// File: rtl/io_port_responder.sv
module io_port_responder
  import io_resp_pkg::*;
#(
  parameter int unsigned NUM_OUT     = 2,
  parameter int unsigned NUM_IN      = 2,
  parameter int unsigned OUT_BASE    = 4,
  parameter int unsigned IN_BASE     = 8,
  parameter int unsigned TIMER_PORT  = 12,
  parameter int unsigned INTCTL_PORT = 13,
  parameter logic [4:0]  WR_CODE     = 5'h1A,
  parameter logic [4:0]  RD_CODE     = 5'h1B
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [4:0]           ctlCode,
  input  logic [7:0]           busIn,
  input  logic [8*NUM_IN-1:0]  inPins,
  output logic [7:0]           busOut,
  output logic                 busOe,
  output logic [8*NUM_OUT-1:0] outPorts,
  output logic [7:0]           timerReg,
  output logic [7:0]           intCtlReg
);

  strobe_t    stb;
  logic [7:0] prevAddr;

  io_resp_ctrl #(
    .NUM_OUT(NUM_OUT), .NUM_IN(NUM_IN), .OUT_BASE(OUT_BASE), .IN_BASE(IN_BASE),
    .TIMER_PORT(TIMER_PORT), .INTCTL_PORT(INTCTL_PORT),
    .WR_CODE(WR_CODE), .RD_CODE(RD_CODE)
  ) i_ctrl (
    .ctlCode (ctlCode),
    .prevAddr(prevAddr),
    .stb     (stb)
  );

  io_resp_dp #(.NUM_OUT(NUM_OUT), .NUM_IN(NUM_IN)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .busIn    (busIn),
    .inPins   (inPins),
    .stb      (stb),
    .prevAddr (prevAddr),
    .outPorts (outPorts),
    .timerReg (timerReg),
    .intCtlReg(intCtlReg),
    .busOut   (busOut),
    .busOe    (busOe)
  );

  // helper terms for the checks below
  int unsigned addrInt;
  logic        inOutRange, inInRange, isWo;
  logic [7:0]  outByte, pinByte;
  always_comb begin
    addrInt    = int'(prevAddr);
    inOutRange = addrInt >= OUT_BASE && addrInt < OUT_BASE + NUM_OUT;
    inInRange  = addrInt >= IN_BASE && addrInt < IN_BASE + NUM_IN;
    isWo       = addrInt == TIMER_PORT || addrInt == INTCTL_PORT;
    outByte    = 8'(outPorts >> (8 * (addrInt - OUT_BASE)));
    pinByte    = 8'(inPins >> (8 * (addrInt - IN_BASE)));
  end

  a_r8_no_drive_off_read: assert property (@(posedge clk) disable iff (!rstN)
    ctlCode != RD_CODE |-> !busOe);

  a_r8_regs_hold: assert property (@(posedge clk) disable iff (!rstN)
    ctlCode != WR_CODE |=> $stable(outPorts) && $stable(timerReg) && $stable(intCtlReg));

  a_r6_wo_hidden: assert property (@(posedge clk) disable iff (!rstN)
    busOe |-> !isWo);

  a_r7_miss_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (ctlCode == RD_CODE && !inOutRange && !inInRange) |-> !busOe);

  a_r4_out_readback: assert property (@(posedge clk) disable iff (!rstN)
    (ctlCode == RD_CODE && inOutRange) |-> busOe && busOut == outByte);

  a_r5_pin_read: assert property (@(posedge clk) disable iff (!rstN)
    (ctlCode == RD_CODE && inInRange && !inOutRange) |-> busOe && busOut == pinByte);

endmodule

// File: tb/test_io_port_responder.sv
module test_io_port_responder;

  localparam logic [4:0] WR = 5'h1A;
  localparam logic [4:0] RD = 5'h1B;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  ctlCode = 5'h1C;
  logic [7:0]  busIn = 8'h00;
  logic [15:0] inPins = 16'hB24E;
  logic [7:0]  busOut;
  logic        busOe;
  logic [15:0] outPorts;
  logic [7:0]  timerReg, intCtlReg;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10ns clk = ~clk;

  io_port_responder i_io_port_responder (
    .clk(clk), .rstN(rstN), .ctlCode(ctlCode), .busIn(busIn), .inPins(inPins),
    .busOut(busOut), .busOe(busOe), .outPorts(outPorts),
    .timerReg(timerReg), .intCtlReg(intCtlReg)
  );

  // reference model state
  logic [7:0] mOut [2];
  logic [7:0] mTim, mInt, mPrev;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic chkRegs(input string tag);
    chk(tag, 32'(outPorts[7:0]),  32'(mOut[0]), "out0");
    chk(tag, 32'(outPorts[15:8]), 32'(mOut[1]), "out1");
    chk(tag, 32'(timerReg),       32'(mTim),    "timer");
    chk(tag, 32'(intCtlReg),      32'(mInt),    "intctl");
  endtask

  task automatic step(input logic [4:0] c, input logic [7:0] b, input string tag);
    logic       eOe;
    logic [7:0] eData;
    @(negedge clk);
    ctlCode = c;
    busIn   = b;
    #1;
    eOe = 1'b0;
    eData = 8'h00;
    if (c == RD) begin
      if (mPrev == 8'd4 || mPrev == 8'd5) begin
        eOe = 1'b1; eData = mOut[mPrev - 8'd4];
      end else if (mPrev == 8'd8 || mPrev == 8'd9) begin
        eOe = 1'b1; eData = (mPrev == 8'd8) ? inPins[7:0] : inPins[15:8];
      end
    end
    chk(tag, 32'(busOe), 32'(eOe), "busOe");
    if (eOe) chk(tag, 32'(busOut), 32'(eData), "busOut");
    chkRegs(tag);
    @(posedge clk);
    if (c == WR) begin
      case (mPrev)
        8'd4:  mOut[0] = b;
        8'd5:  mOut[1] = b;
        8'd12: mTim = b;
        8'd13: mInt = b;
        default: ;
      endcase
    end
    mPrev = b;
  endtask

  initial begin
    #1ms;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    mOut[0] = 8'h00; mOut[1] = 8'h00; mTim = 8'h00; mInt = 8'h00; mPrev = 8'h00;
    busIn = 8'h05; ctlCode = WR;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset values while reset is held under a write code
    chkRegs("R9");
    chk("R9", 32'(busOe), 32'd0, "busOe");
    rstN = 1'b1;

    // R2: write output port 0 and 1
    step(5'h00, 8'h04, "R2");
    step(WR,    8'h5A, "R2");
    step(5'h1C, 8'h05, "R2");
    step(WR,    8'hC3, "R2");
    // R3: timer and interrupt control
    step(5'h03, 8'h0C, "R3");
    step(WR,    8'h77, "R3");
    step(5'h03, 8'h0D, "R3");
    step(WR,    8'h99, "R3");
    // R4: read output ports back
    step(5'h00, 8'h04, "R4");
    step(RD,    8'h00, "R4");
    step(5'h00, 8'h05, "R4");
    step(RD,    8'h11, "R4");
    // R5: read input pins
    step(5'h00, 8'h08, "R5");
    step(RD,    8'h00, "R5");
    inPins = 16'h3CE1;
    step(5'h00, 8'h09, "R5");
    step(RD,    8'h00, "R5");
    // R6: write-only registers are not readable
    step(5'h00, 8'h0C, "R6");
    step(RD,    8'h00, "R6");
    step(5'h00, 8'h0D, "R6");
    step(RD,    8'h00, "R6");
    // R7: unmatched addresses
    step(5'h00, 8'h20, "R7");
    step(WR,    8'hFF, "R7");
    step(5'h00, 8'h07, "R7");
    step(RD,    8'h00, "R7");
    step(5'h00, 8'h08, "R7");
    step(WR,    8'h66, "R7");
    // R8: other codes after a valid address
    step(5'h00, 8'h04, "R8");
    step(5'h14, 8'hEE, "R8");
    step(5'h00, 8'h05, "R8");
    step(5'h1D, 8'hEE, "R8");
    step(5'h1C, 8'hEE, "R8");
    // R1: chained accesses, each bus byte is the next address
    step(5'h00, 8'h04, "R1");
    step(WR,    8'h05, "R1");
    step(WR,    8'h33, "R1");
    step(5'h00, 8'h05, "R1");
    step(RD,    8'h04, "R1");
    step(RD,    8'h00, "R1");
    // R1: pseudo-random sequence
    lfsr = 16'hACE1;
    for (int n = 0; n < 300; n++) begin
      logic [4:0] c;
      logic [7:0] b;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[1:0])
        2'd0: c = WR;
        2'd1: c = RD;
        2'd2: c = 5'h00;
        default: c = 5'h1D;
      endcase
      b = lfsr[8] ? lfsr[15:8] : {4'h0, lfsr[7:4]};
      if (n % 50 == 0) inPins = {lfsr[7:0], lfsr[15:8]};
      step(c, b, "R1");
    end
    @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule